// File: doc/BRIEF.md
# Three-Level Leg Gate Encoder with Shoot-Through States

This block controls the four gate signals of one phase leg in a three-level neutral-point-clamped bridge. The bridge is fed from an impedance network, so shoot-through states are allowed. A modulator presents a requested leg state code on every clock cycle. The block registers the accepted state and drives the gate vector: outer-upper, inner-upper, inner-lower and outer-lower, most significant bit first. It also reports the output voltage level of the leg and a flag that is high during any shoot-through interval.

The normal states are positive, zero and negative. There are three boost states: full, upper and lower shoot-through. Each boost state holds the leg terminal at zero volts. The block refuses any requested step that would toggle more than two gates in one cycle. This covers a direct positive-to-negative swing, which would toggle all four switches. A refused request leaves the gates unchanged and raises a one-cycle step error. An undefined state code is handled in the same way and raises a one-cycle code error. The modulator reaches a boost state by requesting it between two ordinary states. For example, it steps from zero through upper shoot-through to positive, so no extra commutation is added.

Top module: `npc_leg_gate_enc`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block loads the zero state: `gate_q`=0110, `cur_state`=1, `level`=00, and `shoot_thru`, `bad_code` and `step_err` all low.
- R2: The state codes and their gate patterns (outer-upper, inner-upper, inner-lower, outer-lower) are: 0 positive=1100, 1 zero=0110, 2 negative=0011, 3 full shoot-through=1111, 4 upper shoot-through=1110, 5 lower shoot-through=0111. An accepted request appears on `gate_q` one clock edge after it is sampled.
- R3: `level` is a 2-bit two's-complement value: 01 for code 0, 11 for code 2, and 00 for code 1 and every shoot-through code.
- R4: `shoot_thru` is high exactly when the registered state is code 3, 4 or 5.
- R5: A request with code 6 or 7 leaves `gate_q`, `cur_state`, `level` and `shoot_thru` unchanged, and raises `bad_code` for the following cycle only. `bad_code` and `step_err` are never high together.
- R6: A request for code 2 while in code 0, or for code 0 while in code 2, is refused. The outputs hold, and `step_err` is high for the following cycle only.
- R7: Any other legal request whose pattern differs from the current pattern in more than MAX_FLIPS (default 2) gate bits is refused in the same way as R6. Examples are code 2 from code 4 and code 0 from code 5.
- R8: The sequence zero, upper shoot-through, positive produces 0110, 1110, 1100. The sequence negative, lower shoot-through, zero produces 0011, 0111, 0110.
- R9: Requesting the current state keeps every output unchanged and raises no flag.
- R10: Between any two consecutive cycles after reset, `gate_q` changes in at most two bit positions.
- R11: `cur_state` shows the code of the registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_state | input | 3 | Requested leg state code |
| gate_q | output | 4 | Registered gates: outer-upper, inner-upper, inner-lower, outer-lower |
| cur_state | output | 3 | Registered leg state code |
| level | output | 2 | Leg voltage level, two's complement |
| shoot_thru | output | 1 | High while a shoot-through state is held |
| bad_code | output | 1 | One-cycle flag for an undefined request code |
| step_err | output | 1 | One-cycle flag for a refused transition |

## Verification
The bound checker monitors several properties on every cycle:
- `gate_q` is always one of the six defined patterns.
- No edge toggles more than two gates.
- A positive/negative swing is always refused.
- An undefined code always holds the gates.
- The level and shoot-through outputs agree with the gate pattern.
- The two error flags are never high together.

Other behaviour is shown only by the bench's scenarios. This includes the exact commutation sequences through the upper and lower shoot-through states, and the refusal of three-gate steps out of the boost states. It also includes the reset values and the per-code pattern table, which the bench checks against its own reference model under directed and random request streams.

// File: rtl/npc_leg_pkg.sv
package npc_leg_pkg;

    localparam int GATE_W = 4;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        ST_POS   = 3'd0,
        ST_ZERO  = 3'd1,
        ST_NEG   = 3'd2,
        ST_FULL  = 3'd3,
        ST_UPPER = 3'd4,
        ST_LOWER = 3'd5
    } leg_state_e;

    typedef logic [GATE_W-1:0] gate_vec_t;

    typedef struct packed {
        logic       legal;
        leg_state_e st;
    } req_dec_t;

    // Gate order, MSB first: outer-upper, inner-upper, inner-lower, outer-lower.
    function automatic gate_vec_t state_gates(leg_state_e s);
        gate_vec_t g;
        case (s)
            ST_POS:   g = 4'b1100;
            ST_ZERO:  g = 4'b0110;
            ST_NEG:   g = 4'b0011;
            ST_FULL:  g = 4'b1111;
            ST_UPPER: g = 4'b1110;
            ST_LOWER: g = 4'b0111;
            default:  g = 4'b0110;
        endcase
        return g;
    endfunction

    function automatic logic state_is_shoot(leg_state_e s);
        return (s == ST_FULL) || (s == ST_UPPER) || (s == ST_LOWER);
    endfunction

    function automatic logic [1:0] state_level(leg_state_e s);
        logic [1:0] lv;
        case (s)
            ST_POS:  lv = 2'b01;
            ST_NEG:  lv = 2'b11;
            default: lv = 2'b00;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/npc_leg_decode.sv
module npc_leg_decode
    import npc_leg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output req_dec_t          dec
);
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(ST_LOWER);

    always_comb begin
        dec.legal = (code <= LAST_CODE);
        dec.st    = dec.legal ? leg_state_e'(code) : ST_ZERO;
    end
endmodule

// File: rtl/npc_leg_path_check.sv
module npc_leg_path_check
    import npc_leg_pkg::*;
#(
    parameter int MAX_FLIPS = 2
) (
    input  leg_state_e cur_st,
    input  leg_state_e nxt_st,
    output logic       allowed
);
    localparam int CNT_W = $clog2(GATE_W + 1);

    gate_vec_t        diff;
    logic [CNT_W-1:0] flips;
    logic             pole_swap;

    assign diff = state_gates(cur_st) ^ state_gates(nxt_st);

    always_comb begin
        flips = '0;
        for (int i = 0; i < GATE_W; i++) begin
            flips = flips + CNT_W'(diff[i]);
        end
    end

    // A swing between the two outer levels is never a single commutation step.
    assign pole_swap = ((cur_st == ST_POS) && (nxt_st == ST_NEG)) ||
                       ((cur_st == ST_NEG) && (nxt_st == ST_POS));

    assign allowed = !pole_swap && (flips <= CNT_W'(MAX_FLIPS));
endmodule

// File: rtl/npc_leg_state_reg.sv
module npc_leg_state_reg
    import npc_leg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  req_dec_t   dec,
    input  logic       allowed,
    output leg_state_e state_q,
    output gate_vec_t  gate_q,
    output logic [1:0] level_q,
    output logic       shoot_q,
    output logic       bad_q,
    output logic       err_q
);
    logic accept;
    assign accept = dec.legal && allowed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ZERO;
            gate_q  <= state_gates(ST_ZERO);
            level_q <= state_level(ST_ZERO);
            shoot_q <= 1'b0;
            bad_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            bad_q <= !dec.legal;
            err_q <= dec.legal && !allowed;
            if (accept) begin
                state_q <= dec.st;
                gate_q  <= state_gates(dec.st);
                level_q <= state_level(dec.st);
                shoot_q <= state_is_shoot(dec.st);
            end
        end
    end
endmodule

// File: rtl/npc_leg_gate_enc.sv
module npc_leg_gate_enc
    import npc_leg_pkg::*;
#(
    parameter int MAX_FLIPS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] req_state,
    output logic [GATE_W-1:0] gate_q,
    output logic [CODE_W-1:0] cur_state,
    output logic [1:0]        level,
    output logic              shoot_thru,
    output logic              bad_code,
    output logic              step_err
);
    req_dec_t   dec;
    leg_state_e state_q;
    logic       allowed;

    npc_leg_decode u_dec (
        .code (req_state),
        .dec  (dec)
    );

    npc_leg_path_check #(.MAX_FLIPS(MAX_FLIPS)) u_path (
        .cur_st  (state_q),
        .nxt_st  (dec.st),
        .allowed (allowed)
    );

    npc_leg_state_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .allowed (allowed),
        .state_q (state_q),
        .gate_q  (gate_q),
        .level_q (level),
        .shoot_q (shoot_thru),
        .bad_q   (bad_code),
        .err_q   (step_err)
    );

    assign cur_state = state_q;
endmodule

// File: rtl/npc_leg_checker.sv
module npc_leg_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] req_state,
    input logic [3:0] gate_q,
    input logic [2:0] cur_state,
    input logic [1:0] level,
    input logic       shoot_thru,
    input logic       bad_code,
    input logic       step_err
);
    logic seen_rst = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
    end

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        !$past(rst) |-> ($countones(gate_q ^ $past(gate_q)) <= 2)); // R10

    AST_PATTERN_SET: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        gate_q inside {4'b1100, 4'b0110, 4'b0011, 4'b1111, 4'b1110, 4'b0111}); // R2

    AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (!$past(rst) && $past(req_state) > 3'd5) |-> ($stable(gate_q) && bad_code)); // R5

    AST_POLE_SWAP_REFUSED: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (!$past(rst) && (($past(cur_state) == 3'd0 && $past(req_state) == 3'd2) ||
                         ($past(cur_state) == 3'd2 && $past(req_state) == 3'd0)))
        |-> (step_err && $stable(gate_q))); // R6

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        !(bad_code && step_err)); // R5

    AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        level == ((gate_q == 4'b1100) ? 2'b01 : (gate_q == 4'b0011) ? 2'b11 : 2'b00)); // R3

    AST_SHOOT_MATCH: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        shoot_thru == ($countones(gate_q) >= 3)); // R4
endmodule

bind npc_leg_gate_enc npc_leg_checker u_chk (.*);

// File: tb/npc_leg_gate_enc_test.sv
module npc_leg_gate_enc_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req_state = 3'd1;
    logic [3:0] gate_q;
    logic [2:0] cur_state;
    logic [1:0] level;
    logic       shoot_thru;
    logic       bad_code;
    logic       step_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // Reference model state
    logic [2:0] m_state;
    logic [3:0] m_prev_gates;
    logic       m_bad;
    logic       m_err;

    always #10 clk = ~clk; // 50 MHz

    npc_leg_gate_enc uut (
        .clk(clk), .rst(rst), .req_state(req_state), .gate_q(gate_q),
        .cur_state(cur_state), .level(level), .shoot_thru(shoot_thru),
        .bad_code(bad_code), .step_err(step_err)
    );

    function automatic logic [3:0] ref_gates(logic [2:0] c);
        case (c)
            3'd0: return 4'b1100;
            3'd1: return 4'b0110;
            3'd2: return 4'b0011;
            3'd3: return 4'b1111;
            3'd4: return 4'b1110;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic int ones4(logic [3:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        logic [1:0] exp_lv;
        exp_lv = (m_state == 3'd0) ? 2'b01 : (m_state == 3'd2) ? 2'b11 : 2'b00;
        check(tag, "gate_q", {4'd0, gate_q}, {4'd0, ref_gates(m_state)});
        check("R11", "cur_state", {5'd0, cur_state}, {5'd0, m_state});
        check("R3", "level", {6'd0, level}, {6'd0, exp_lv});
        check("R4", "shoot_thru", {7'd0, shoot_thru}, {7'd0, (m_state >= 3'd3)});
        check(tag, "bad_code", {7'd0, bad_code}, {7'd0, m_bad});
        check(tag, "step_err", {7'd0, step_err}, {7'd0, m_err});
        check("R10", "gate flips<=2", {7'd0, (ones4(gate_q ^ m_prev_gates) <= 2)}, 8'd1);
        m_prev_gates = gate_q;
    endtask

    task automatic apply(logic [2:0] code);
        string tag;
        int    fl;
        req_state = code;
        @(posedge clk);
        #5;
        m_bad = 1'b0;
        m_err = 1'b0;
        if (code > 3'd5) begin
            m_bad = 1'b1;
            tag = "R5";
        end else if ((m_state == 3'd0 && code == 3'd2) || (m_state == 3'd2 && code == 3'd0)) begin
            m_err = 1'b1;
            tag = "R6";
        end else begin
            fl = ones4(ref_gates(m_state) ^ ref_gates(code));
            if (fl > 2) begin
                m_err = 1'b1;
                tag = "R7";
            end else if (code == m_state) begin
                tag = "R9";
            end else begin
                m_state = code;
                tag = "R2";
            end
        end
        compare_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        m_state = 3'd1;
        m_bad = 1'b0;
        m_err = 1'b0;
        m_prev_gates = 4'b0110;
        rst = 1'b1;
        req_state = 3'd0;
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        check("R1", "gate_q", {4'd0, gate_q}, 8'h06);
        check("R1", "cur_state", {5'd0, cur_state}, 8'd1);
        check("R1", "level", {6'd0, level}, 8'd0);
        check("R1", "flags", {5'd0, shoot_thru, bad_code, step_err}, 8'd0);
        @(negedge clk);
        rst = 1'b0;

        // R8 zero -> upper shoot-through -> positive
        apply(3'd4);
        check("R8", "O->UST", {4'd0, gate_q}, 8'b1110);
        apply(3'd0);
        check("R8", "UST->P", {4'd0, gate_q}, 8'b1100);
        apply(3'd0);            // R9 hold
        apply(3'd2);            // R6 refused
        apply(3'd5);            // R7 P->LST refused
        apply(3'd1);
        apply(3'd2);
        // R8 negative -> lower shoot-through -> zero
        apply(3'd5);
        check("R8", "N->LST", {4'd0, gate_q}, 8'b0111);
        apply(3'd1);
        check("R8", "LST->O", {4'd0, gate_q}, 8'b0110);
        apply(3'd6);            // R5
        apply(3'd7);            // R5 back to back
        apply(3'd3);            // full shoot-through
        apply(3'd2);
        apply(3'd0);            // R6 refused from N
        apply(3'd4);            // R7 N->UST refused
        apply(3'd7);
        apply(3'd1);

        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            c = 3'($urandom % 8);
            apply(c);
        end

        // R1 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #5;
        check("R1", "gate_q after reset", {4'd0, gate_q}, 8'h06);
        check("R1", "flags after reset", {5'd0, shoot_thru, bad_code, step_err}, 8'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule